// File: doc/BRIEF.md
# Command-Queue SPI Sequencer

This block runs a single-lane SPI bus from a queue of self-describing 20-bit command words instead of per-byte register writes. Each word names the chip selects to drive, the direction and the length of one bus phase: a chip-select hold with a count of idle clock periods, a single immediate command byte, or a data run of up to 255 bytes or a power-of-two number of bytes. The block pops one word at a time from an internal command FIFO and runs it to completion before it pops the next.

Transmit data comes from an internal FIFO of 32-bit words. Received bytes leave on a valid-qualified byte stream that has no backpressure. The serial clock is the reference clock divided by `2 << clk_div`. Clock polarity and phase are static inputs and follow the usual SPI modes 0 to 3. There are two active-low chip selects, a lower one and an upper one.

Top module: `spi_cmd_engine`

## Requirements
- R1: Command word fields. Bits [7:0] are the immediate, bit 8 the data flag, bit 9 the exponent flag, bit 12 the lower select, bit 13 the upper select, bit 16 transmit and bit 17 receive. The lane-mode bits [11:10], the bus-select bits 14 and 15 and the striping bit 18 have no effect: every word runs on the single lane. Words run in the order they were pushed.
- R2: A word with the data and transmit flags both clear drives the selects named by bits 12 and 13 (a set bit asserts that select low). It then holds for immediate × (2 << clk_div) reference cycles with no SCLK edge.
- R3: A word with the data flag clear and the transmit flag set shifts out its immediate as one byte, MSB first, and takes no word from the TX FIFO.
- R4: A word with the data flag set and the exponent flag clear moves as many bytes as the immediate gives.
- R5: A word with both the data and exponent flags set moves 2^immediate bytes. The immediate must be at least 8 and below LEN_W.
- R6: A data word of length zero finishes at once and makes no SCLK edge.
- R7: In a transmit data word, bytes are taken from 32-bit TX words least significant byte first, and a new word is popped after every four bytes. Each data word starts on a fresh TX word, and bytes left over in a partly used word are dropped. A data word without the transmit flag drives MOSI low.
- R8: In a data word with the receive flag set, each byte is assembled MSB first from MISO and is presented on rx_byte with a one-cycle rx_valid pulse. Other words produce no rx_valid.
- R9: SCLK rests at cpol between bytes. Within a byte, consecutive leading edges are 2 << clk_div reference cycles apart.
- R10: With cpha = 0, MOSI is valid before the leading edge, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With cpha = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R11: Both selects are deasserted after reset. A select changes only when a new word is popped and holds its level between words.
- R12: cmd_empty is high when the command FIFO holds no word. tx_not_full is low when the TX FIFO is full. A push into a full FIFO is ignored.
- R13: If the TX FIFO is empty when a transmit byte needs a new word, SCLK stops until a word arrives. No byte is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_push | input | 1 | Push cmd_word into the command FIFO |
| cmd_word | input | 20 | Command word |
| cmd_empty | output | 1 | Command FIFO holds no word |
| tx_push | input | 1 | Push tx_word into the TX FIFO |
| tx_word | input | 32 | Transmit data word |
| tx_not_full | output | 1 | TX FIFO can take a word |
| clk_div | input | 3 | SCLK divider exponent |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | Sampling-edge select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_lo_n | output | 1 | Lower chip select, active low |
| cs_up_n | output | 1 | Upper chip select, active low |
| miso | input | 1 | Serial data in |
| rx_valid | output | 1 | rx_byte is valid this cycle |
| rx_byte | output | 8 | Received byte |

## Verification
The bench builds the block with TX_DEPTH = 4, CMD_DEPTH = 8 and LEN_W = 20. A shallow TX FIFO makes the full flag, the ignored fifth push and the empty-FIFO stall reachable with a handful of words. The bench sweeps all four clock modes over divider values 0 to 2, which keeps every run short. At divider 0 a 256-byte exponent run stays affordable, so a run longer than any immediate length is exercised end to end.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int ENTRY_W = 20;
  localparam int F_DATA  = 8;
  localparam int F_EXP   = 9;
  localparam int F_CSL   = 12;
  localparam int F_CSU   = 13;
  localparam int F_TX    = 16;
  localparam int F_RX    = 17;

  typedef enum logic [1:0] {XS_IDLE, XS_WAIT, XS_LOAD, XS_BIT} xstate_t;

  // Byte count of a data word: plain immediate, or 2^immediate with the exponent flag
  function automatic logic [31:0] entry_len(input logic [ENTRY_W-1:0] e);
    if (e[F_EXP]) return 32'd1 << e[7:0];
    return {24'd0, e[7:0]};
  endfunction

  // Terminal count of the half-period counter: half period is 1 << div cycles
  function automatic logic [6:0] half_lim(input logic [2:0] div);
    return (7'd1 << div) - 7'd1;
  endfunction
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // The reader only pops when a word is present
  assert_pop_nonempty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // A push into a full FIFO leaves the occupancy unchanged when nothing pops
  assert_full_push_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/spi_cmd_exec.sv
module spi_cmd_exec
  import spi_cmd_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] cmd_entry,
  input  logic               cmd_avail,
  output logic               cmd_pop,
  input  logic [31:0]        tx_word,
  input  logic               tx_avail,
  output logic               tx_pop,
  input  logic [2:0]         clk_div,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_lo_n,
  output logic               cs_up_n,
  output logic               rx_valid,
  output logic [7:0]         rx_byte
);
  xstate_t          st;
  logic [7:0]       e_imm;
  logic             e_data, e_tx, e_rx;
  logic             cs_lo, cs_up;
  logic [LEN_W-1:0] left;
  logic [31:0]      word;
  logic [1:0]       bsel;
  logic [7:0]       sh, rsh;
  logic [2:0]       bitc;
  logic             half;
  logic [6:0]       dcnt;
  logic [8:0]       hleft;

  // Named internal events
  logic tick_en, tick, need_word, load_go, byte_end;
  logic [7:0] next_byte;
  logic unused_fields;

  assign unused_fields = ^{cmd_entry[19:18], cmd_entry[15:14], cmd_entry[11:10]};

  assign tick_en   = (st == XS_WAIT) || (st == XS_BIT);
  assign tick      = tick_en && (dcnt == half_lim(clk_div));
  assign need_word = e_data && e_tx && (bsel == 2'd0);
  assign load_go   = (st == XS_LOAD) && (left != '0) && !(need_word && !tx_avail);
  assign byte_end  = (st == XS_BIT) && tick && half && (bitc == 3'd7);
  assign cmd_pop   = (st == XS_IDLE) && cmd_avail;
  assign tx_pop    = load_go && need_word;

  always_comb begin
    if (!e_data)           next_byte = e_imm;
    else if (!e_tx)        next_byte = 8'h00;
    else if (bsel == 2'd0) next_byte = tx_word[7:0];
    else                   next_byte = word[{bsel, 3'b000} +: 8];
  end

  assign sclk    = (st == XS_BIT) ? (cpol ^ cpha ^ half) : cpol;
  assign mosi    = sh[7];
  assign cs_lo_n = !cs_lo;
  assign cs_up_n = !cs_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt <= '0;
    else if (!tick_en || tick) dcnt <= '0;
    else              dcnt <= dcnt + 7'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= XS_IDLE; e_imm <= '0; e_data <= 1'b0; e_tx <= 1'b0; e_rx <= 1'b0;
      cs_lo <= 1'b0; cs_up <= 1'b0; left <= '0; word <= '0; bsel <= '0;
      sh <= '0; rsh <= '0; bitc <= '0; half <= 1'b0; hleft <= '0;
      rx_valid <= 1'b0; rx_byte <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        XS_IDLE: if (cmd_avail) begin
          e_imm  <= cmd_entry[7:0];
          e_data <= cmd_entry[F_DATA];
          e_tx   <= cmd_entry[F_TX];
          e_rx   <= cmd_entry[F_RX];
          cs_lo  <= cmd_entry[F_CSL];
          cs_up  <= cmd_entry[F_CSU];
          bsel   <= '0;
          if (cmd_entry[F_DATA]) begin
            left <= LEN_W'(entry_len(cmd_entry));
            st   <= XS_LOAD;
          end else if (cmd_entry[F_TX]) begin
            left <= LEN_W'(1);
            st   <= XS_LOAD;
          end else begin
            hleft <= {cmd_entry[7:0], 1'b0};
            st    <= (cmd_entry[7:0] != 8'd0) ? XS_WAIT : XS_IDLE;
          end
        end
        XS_WAIT: if (tick) begin
          hleft <= hleft - 9'd1;
          if (hleft == 9'd1) st <= XS_IDLE;
        end
        XS_LOAD: begin
          if (left == '0) st <= XS_IDLE;
          else if (load_go) begin
            sh <= next_byte;
            if (need_word) word <= tx_word;
            if (e_data && e_tx) bsel <= bsel + 2'd1;
            bitc <= '0;
            half <= 1'b0;
            st   <= XS_BIT;
          end
        end
        XS_BIT: if (tick) begin
          if (!half) begin
            half <= 1'b1;
            rsh  <= {rsh[6:0], miso};
          end else begin
            half <= 1'b0;
            sh   <= {sh[6:0], 1'b0};
            bitc <= bitc + 3'd1;
            if (bitc == 3'd7) begin
              left     <= left - LEN_W'(1);
              rx_valid <= e_data && e_rx;
              rx_byte  <= rsh;
              st       <= XS_LOAD;
            end
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  // Selects move only when a word is popped
  assert_cs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_pop |=> $stable({cs_lo_n, cs_up_n}));
  // A hold word produces no SCLK edge
  assert_hold_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XS_WAIT && $past(st) == XS_WAIT) |-> $stable(sclk));
  // A zero-length word returns to idle with SCLK at rest
  assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XS_LOAD && left == '0) |=> (st == XS_IDLE && sclk == cpol));
  // A TX word pop starts a new group of four bytes
  assert_tx_pop_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (bsel == 2'd1));
  // Received bytes appear only as a byte ends
  assert_rx_at_byte_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(st) == XS_BIT && st == XS_LOAD));
  // SCLK rests at cpol outside a byte
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XS_IDLE || st == XS_WAIT) |-> (sclk == cpol));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CMD_DEPTH = 8,
  parameter int TX_DEPTH  = 8,
  parameter int LEN_W     = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_push,
  input  logic [ENTRY_W-1:0] cmd_word,
  output logic               cmd_empty,
  input  logic               tx_push,
  input  logic [31:0]        tx_word,
  output logic               tx_not_full,
  input  logic [2:0]         clk_div,
  input  logic               cpol,
  input  logic               cpha,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_lo_n,
  output logic               cs_up_n,
  input  logic               miso,
  output logic               rx_valid,
  output logic [7:0]         rx_byte
);
  logic [ENTRY_W-1:0] cmd_head;
  logic [31:0]        tx_head;
  logic cmd_pop, tx_pop, cmd_full, tx_empty, tx_full;

  spi_cmd_fifo #(.W(ENTRY_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_word),
    .pop(cmd_pop), .dout(cmd_head), .empty(cmd_empty), .full(cmd_full));

  spi_cmd_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_word),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

  assign tx_not_full = !tx_full;

  spi_cmd_exec #(.LEN_W(LEN_W)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .cmd_entry(cmd_head), .cmd_avail(!cmd_empty), .cmd_pop(cmd_pop),
    .tx_word(tx_head), .tx_avail(!tx_empty), .tx_pop(tx_pop),
    .clk_div(clk_div), .cpol(cpol), .cpha(cpha), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_lo_n(cs_lo_n), .cs_up_n(cs_up_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte));

  // The command queue never reports full and empty together
  assert_cmdq_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_full && cmd_empty));
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 1024;

  logic clk = 0, rst_n = 0;
  logic cmd_push = 0, tx_push = 0;
  logic [19:0] cmd_word = '0;
  logic [31:0] tx_word = '0;
  logic [2:0] clk_div = 0;
  logic cpol = 0, cpha = 0, miso = 0;
  logic cmd_empty, tx_not_full, sclk, mosi, cs_lo_n, cs_up_n, rx_valid;
  logic [7:0] rx_byte;

  spi_cmd_engine #(.CMD_DEPTH(8), .TX_DEPTH(4), .LEN_W(20)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Slave and bus monitor
  logic [7:0] mlog [LOGN];
  logic [7:0] rlog [LOGN];
  int nb = 0, nr = 0, bitc = 0, sp = 0, lpos = 0;
  int edges = 0, edges_nocs = 0, last_lead = 0, ivmin = 1 << 30, ivmax = 0;
  int cs_fall = 0, gap = -1;
  bit mon_en = 0, seen_fall = 0;
  logic [7:0] mbits = 0;

  function automatic logic [7:0] sbyte(input int n);
    return 8'((n * 37 + 11) & 255);
  endfunction
  function automatic logic sbit(input int p);
    logic [7:0] b;
    b = sbyte(p / 8);
    return b[7 - (p % 8)];
  endfunction
  function automatic logic [31:0] twd(input int c, input int j);
    return 32'h5A3C9671 ^ (32'(c) * 32'h01010101) ^ (32'(j) * 32'h11223344);
  endfunction

  always @(negedge cs_lo_n) if (mon_en) begin cs_fall = cyc; seen_fall = 1; end

  always @(posedge sclk or negedge sclk) if (mon_en) begin
    bit lead;
    lead = (sclk != cpol);
    edges++;
    if (cs_lo_n && cs_up_n) edges_nocs++;
    if (seen_fall) begin gap = cyc - cs_fall; seen_fall = 0; end
    if (lead) begin
      if (lpos != 0) begin
        if (cyc - last_lead < ivmin) ivmin = cyc - last_lead;
        if (cyc - last_lead > ivmax) ivmax = cyc - last_lead;
      end
      last_lead = cyc;
      lpos = (lpos + 1) % 8;
    end
    if ((cpha == 0) == lead) begin
      mbits = {mbits[6:0], mosi};
      bitc++;
      if (bitc == 8) begin mlog[nb % LOGN] = mbits; nb++; bitc = 0; end
    end else if (cpha == 0) begin
      sp++; miso = sbit(sp);
    end else begin
      miso = sbit(sp); sp++;
    end
  end

  always @(negedge clk) if (rx_valid) begin rlog[nr % LOGN] = rx_byte; nr++; end

  task automatic push_cmd(input logic [19:0] w);
    @(negedge clk); cmd_word = w; cmd_push = 1;
    @(negedge clk); cmd_push = 0;
  endtask
  task automatic push_tx(input logic [31:0] w);
    @(negedge clk); tx_word = w; tx_push = 1;
    @(negedge clk); tx_push = 0;
  endtask
  task automatic set_cfg(input int d, input int pol, input int pha);
    mon_en = 0;
    @(negedge clk);
    clk_div = 3'(d); cpol = 1'(pol); cpha = 1'(pha);
    repeat (2) @(negedge clk);
    sp = nb * 8; bitc = 0; lpos = 0;
    if (cpha == 0) miso = sbit(sp);
    ivmin = 1 << 30; ivmax = 0;
    mon_en = 1;
  endtask
  task automatic settle();
    wait (cmd_empty);
    repeat (12 * (2 << clk_div) + 8) @(negedge clk);
  endtask

  localparam logic [19:0] LO   = 20'h05000; // lower select, lower bus, single lane
  localparam logic [19:0] TXF  = 20'h10000;
  localparam logic [19:0] RXF  = 20'h20000;
  localparam logic [19:0] DATF = 20'h00100;
  localparam logic [19:0] EXPF = 20'h00200;
  localparam logic [19:0] REL  = 20'h04405; // lower bus, selects clear, 5 periods

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_lo_n && cs_up_n, "R11", "selects after reset", {cs_lo_n, cs_up_n}, 3);
    chk(sclk == 0, "R9", "sclk after reset", sclk, 0);
    chk(cmd_empty && tx_not_full && !rx_valid, "R12", "status after reset",
        {cmd_empty, tx_not_full, rx_valid}, 3'b110);

    // Mode and divider sweep
    c = 0;
    for (int d = 0; d < 3; d++) for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++) begin
        int ltx, lrx, n0, r0, per;
        logic [7:0] op, eb;
        set_cfg(d, pol, pha);
        ltx = 1 + c % 6; lrx = 1 + (c * 5) % 6; per = 2 << d;
        op = 8'(8'hA5 ^ c);
        n0 = nb; r0 = nr;
        for (int j = 0; j < (ltx + 3) / 4; j++) push_tx(twd(c, j));
        push_cmd(LO | 20'h00005);
        push_cmd(LO | TXF | 20'(op));
        push_cmd(LO | TXF | DATF | 20'(ltx));
        push_cmd(LO | RXF | DATF | 20'(lrx));
        push_cmd(LO | TXF | DATF);
        push_cmd(REL);
        settle();
        chk(nb - n0 == 1 + ltx + lrx, "R4", "byte count (R6 zero word adds none)",
            nb - n0, 1 + ltx + lrx);
        chk(mlog[n0 % LOGN] == op, "R3", "immediate byte", mlog[n0 % LOGN], op);
        for (int k = 0; k < ltx; k++) begin
          logic [31:0] w;
          w = twd(c, k / 4); eb = w[8 * (k % 4) +: 8];
          chk(mlog[(n0 + 1 + k) % LOGN] == eb, "R7", "tx byte",
              mlog[(n0 + 1 + k) % LOGN], eb);
        end
        chk(nr - r0 == lrx, "R8", "rx count", nr - r0, lrx);
        for (int k = 0; k < lrx; k++) begin
          eb = sbyte(n0 + 1 + ltx + k);
          chk(rlog[(r0 + k) % LOGN] == eb, "R10", "rx byte",
              rlog[(r0 + k) % LOGN], eb);
          chk(mlog[(n0 + 1 + ltx + k) % LOGN] == 0, "R7", "mosi low on rx word",
              mlog[(n0 + 1 + ltx + k) % LOGN], 0);
        end
        chk(ivmin == per && ivmax == per, "R9", "sclk period", ivmax, per);
        chk(sclk == cpol, "R9", "sclk rest level", sclk, cpol);
        chk(gap >= 5 * per, "R2", "hold before first edge", gap, 5 * per);
        chk(cs_lo_n && cs_up_n, "R11", "selects released", {cs_lo_n, cs_up_n}, 3);
        c++;
      end

    // Exponent run: 2^8 receive bytes
    begin
      int n0, r0, bad;
      set_cfg(0, 0, 0);
      n0 = nb; r0 = nr; bad = 0;
      push_cmd(LO | 20'h00005);
      push_cmd(LO | RXF | DATF | EXPF | 20'd8);
      push_cmd(REL);
      settle();
      chk(nr - r0 == 256, "R5", "exponent rx count", nr - r0, 256);
      for (int k = 0; k < 256; k++)
        if (rlog[(r0 + k) % LOGN] != sbyte(n0 + k)) bad++;
      chk(bad == 0, "R5", "exponent rx data mismatches", bad, 0);
    end

    // TX FIFO full, ignored push, stall on empty
    begin
      int n0, e0;
      n0 = nb;
      for (int j = 0; j < 4; j++) push_tx(twd(40, j));
      chk(!tx_not_full, "R12", "tx full after four words", tx_not_full, 0);
      push_tx(twd(41, 0));
      push_cmd(LO | 20'h00005);
      push_cmd(LO | TXF | DATF | 20'd16);
      push_cmd(LO | TXF | DATF | 20'd4);
      wait (nb == n0 + 16);
      repeat (200) @(negedge clk);
      e0 = edges;
      repeat (100) @(negedge clk);
      chk(nb == n0 + 16 && edges == e0, "R13", "stall with empty tx fifo", edges - e0, 0);
      push_tx(twd(42, 0));
      push_cmd(REL);
      settle();
      for (int k = 0; k < 20; k++) begin
        logic [31:0] w;
        logic [7:0] eb;
        w = (k < 16) ? twd(40, k / 4) : twd(42, 0);
        eb = w[8 * (k % 4) +: 8];
        chk(mlog[(n0 + k) % LOGN] == eb, "R12", "tx byte after ignored push",
            mlog[(n0 + k) % LOGN], eb);
      end
    end

    // Upper select with ignored lane, bus and striping bits
    begin
      int n0;
      n0 = nb;
      push_cmd(20'h0A000 | 20'h00005);
      push_cmd(20'h0A000 | TXF | 20'h40000 | 20'h00C00 | 20'h0003C);
      repeat (4) @(negedge clk);
      chk(!cs_up_n && cs_lo_n, "R1", "upper select only", {cs_lo_n, cs_up_n}, 2'b10);
      push_cmd(20'h08005);
      settle();
      chk(nb - n0 == 1 && mlog[n0 % LOGN] == 8'h3C, "R1", "single-lane byte",
          mlog[n0 % LOGN], 8'h3C);
      chk(cs_up_n, "R11", "upper released", cs_up_n, 1);
    end

    // Command queue occupancy
    push_cmd(20'h00028); push_cmd(20'h00028); push_cmd(20'h00028);
    chk(!cmd_empty, "R12", "cmd queue not empty", cmd_empty, 0);
    settle();
    chk(cmd_empty, "R12", "cmd queue drained", cmd_empty, 1);
    chk(edges_nocs == 0, "R2", "edges with no select", edges_nocs, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule